// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects eight edge-triggered interrupt requests. It resolves them by fixed priority in fully nested order and raises one interrupt line toward a processor. The processor programs it through a byte-wide port pair. A one-bit address picks the command port (0) or the data port (1). Writes to the command port carry the start-of-initialization word and the operation commands. Writes to the data port carry the rest of the initialization words and, once initialization is done, the mask.

While `ack_i` is high the controller presents an 8-bit vector: the programmed base with the granted level in its low three bits. At the clock edge that ends the acknowledge, the granted request moves from the request register into the in-service register. Software closes a service routine with an end-of-interrupt command, either non-specific or specific. It can read back the request, in-service and mask registers. It can also use poll mode instead of the acknowledge cycle, and special mask mode so that a masked in-service level no longer blocks lower levels. The stored cascade word only appears on an output; no multi-chip bus is built.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the controller is uninitialized: irq_o is low, the mask reads 0xFF, read-back selects the request register, and data-port writes are ignored until an initialization sequence completes.
- R2: A command-port write with bit 4 set starts initialization. It clears the mask, the in-service register, special mask mode and a pending poll, and it selects request read-back. The next data-port writes are taken in turn as the base, then the cascade word (skipped when the start word has bit 1 set), then the mode word (taken only when the start word has bit 0 set). After that the controller is ready.
- R3: The vector is the base with bits 2:0 replaced by the granted level. cascade_o shows the last cascade word written.
- R4: A rising edge on req_i[k] sets request bit k, whether or not k is masked. The bit clears when level k is acknowledged. A request held high does not set the bit again.
- R5: When ready, a data-port write loads the mask. A set mask bit keeps that level from raising irq_o. A command-port read returns the mask.
- R6: Level 0 has the highest priority. irq_o is high when the controller is ready and the highest-priority unmasked pending level is above every set in-service level.
- R7: An acknowledge while a level is granted moves that level from request to in-service. An acknowledge with no grant shows level 7 in the vector and changes no state.
- R8: A command write with bits 4:3 = 00 and bits 7:5 = 001 clears the highest-priority set in-service bit.
- R9: A command write with bits 4:3 = 00 and bits 7:5 = 011 clears the in-service bit named by bits 2:0.
- R10: A command write with bits 4:3 = 00 and any other bits 7:5 code changes no state.
- R11: A command write with bits 4:3 = 01 and bit 1 set selects data-port read-back: the in-service register if bit 0 = 1, the request register if bit 0 = 0. With bit 1 clear the selection is kept.
- R12: In the same command, bit 6 set loads special mask mode from bit 5. In that mode, in-service bits that are masked do not block lower-priority levels.
- R13: In the same command, bit 2 arms a poll. The next read of either port returns bit 7 = pending, bits 6:3 = 0 and bits 2:0 = the granted level (0 if none). A pending level is acknowledged by that read. The poll ends after one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | Port select: 0 command, 1 data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (side effects only in poll) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| req_i | input | 8 | Interrupt requests, edge-triggered |
| irq_o | output | 1 | Interrupt to processor |
| ack_i | input | 1 | Interrupt acknowledge |
| vector_o | output | 8 | Vector of the granted level |
| cascade_o | output | 8 | Stored cascade word |

## Verification
The assertions check on every cycle that irq_o stays low until initialization completes, and that irq_o is never high without an unmasked pending request. They also check that an acknowledge or a successful poll read leaves an in-service bit set, and that a specific end-of-interrupt clears its named bit. Nested pre-emption order, the effect of special mask mode, read-back selection, the shortened initialization sequences and the single-shot poll only show up in the bench scenarios. There a behavioural model predicts irq_o, vector_o and rdata_o on every clock.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_BASE,
    ST_CASC,
    ST_MODE,
    ST_RUN
  } init_st_e;

  localparam logic [2:0] EOI_NONSPEC = 3'b001;
  localparam logic [2:0] EOI_SPEC    = 3'b011;
endpackage

// File: rtl/pic8_first_set.sv
module pic8_first_set #(
  parameter int unsigned N     = 8,
  parameter int unsigned LVL_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic             valid_o,
  output logic [LVL_W-1:0] idx_o
);
  always_comb begin
    valid_o = |vec_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = LVL_W'(i);
    end
  end
endmodule

// File: rtl/pic8_cfg.sv
module pic8_cfg
  import pic8_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned LVL_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [N-1:0]     wdata_i,
  output logic             ready_o,
  output logic [N-1:0]     imr_o,
  output logic [N-1:0]     base_o,
  output logic [N-1:0]     casc_o,
  output logic             smm_o,
  output logic             rsel_isr_o,
  output logic             poll_o,
  output logic             init_o,
  output logic             eoi_ns_o,
  output logic             eoi_sp_o,
  output logic [LVL_W-1:0] eoi_lvl_o
);
  init_st_e   st_q;
  logic       need_casc_q, need_mode_q;
  logic       cmd_wr, dat_wr, is_ocw2, is_ocw3;

  assign cmd_wr  = wr_i & ~addr_i;
  assign dat_wr  = wr_i & addr_i;
  assign init_o  = cmd_wr & wdata_i[4];
  assign is_ocw3 = cmd_wr & ~wdata_i[4] & wdata_i[3];
  assign is_ocw2 = cmd_wr & ~wdata_i[4] & ~wdata_i[3];

  assign eoi_ns_o  = is_ocw2 && (wdata_i[7:5] == EOI_NONSPEC);
  assign eoi_sp_o  = is_ocw2 && (wdata_i[7:5] == EOI_SPEC);
  assign eoi_lvl_o = wdata_i[LVL_W-1:0];
  assign ready_o   = (st_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_OFF;
      need_casc_q <= 1'b0;
      need_mode_q <= 1'b0;
      imr_o       <= '1;
      base_o      <= '0;
      casc_o      <= '0;
      smm_o       <= 1'b0;
      rsel_isr_o  <= 1'b0;
      poll_o      <= 1'b0;
    end else begin
      if (rd_i && poll_o) poll_o <= 1'b0;
      if (init_o) begin
        st_q        <= ST_BASE;
        need_casc_q <= ~wdata_i[1];
        need_mode_q <= wdata_i[0];
        imr_o       <= '0;
        smm_o       <= 1'b0;
        rsel_isr_o  <= 1'b0;
        poll_o      <= 1'b0;
      end else if (dat_wr) begin
        unique case (st_q)
          ST_BASE: begin
            base_o <= wdata_i;
            st_q   <= need_casc_q ? ST_CASC : (need_mode_q ? ST_MODE : ST_RUN);
          end
          ST_CASC: begin
            casc_o <= wdata_i;
            st_q   <= need_mode_q ? ST_MODE : ST_RUN;
          end
          ST_MODE: st_q  <= ST_RUN;  // only one processor mode exists
          ST_RUN:  imr_o <= wdata_i;
          default: ;
        endcase
      end else if (is_ocw3) begin
        if (wdata_i[6]) smm_o <= wdata_i[5];
        if (wdata_i[1]) rsel_isr_o <= wdata_i[0];
        if (wdata_i[2]) poll_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pic8_regs.sv
module pic8_regs #(
  parameter int unsigned N     = 8,
  parameter int unsigned LVL_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic [N-1:0]     imr_i,
  input  logic             smm_i,
  input  logic             ready_i,
  input  logic             init_i,
  input  logic             take_i,
  input  logic             eoi_ns_i,
  input  logic             eoi_sp_i,
  input  logic [LVL_W-1:0] eoi_lvl_i,
  output logic [N-1:0]     irr_o,
  output logic [N-1:0]     isr_o,
  output logic             grant_o,
  output logic [LVL_W-1:0] grant_lvl_o
);
  logic [N-1:0]     prev_q, irr_q, isr_q;
  logic [N-1:0]     pend, eff_isr, take_mask, clr_mask;
  logic             pend_v, eff_v, top_v;
  logic [LVL_W-1:0] pend_lvl, eff_lvl, top_lvl;

  assign pend    = irr_q & ~imr_i;
  assign eff_isr = smm_i ? (isr_q & ~imr_i) : isr_q;

  pic8_first_set #(.N(N), .LVL_W(LVL_W)) u_pend (.vec_i(pend),    .valid_o(pend_v), .idx_o(pend_lvl));
  pic8_first_set #(.N(N), .LVL_W(LVL_W)) u_blk  (.vec_i(eff_isr), .valid_o(eff_v),  .idx_o(eff_lvl));
  pic8_first_set #(.N(N), .LVL_W(LVL_W)) u_top  (.vec_i(isr_q),   .valid_o(top_v),  .idx_o(top_lvl));

  assign grant_o     = ready_i && pend_v && (!eff_v || (pend_lvl < eff_lvl));
  assign grant_lvl_o = pend_lvl;

  always_comb begin
    take_mask = '0;
    clr_mask  = '0;
    if (take_i && grant_o) take_mask = N'(1) << pend_lvl;
    if (eoi_ns_i && top_v) clr_mask = N'(1) << top_lvl;
    if (eoi_sp_i)          clr_mask = N'(1) << eoi_lvl_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[g] <= 1'b0;
        irr_q[g]  <= 1'b0;
        isr_q[g]  <= 1'b0;
      end else begin
        prev_q[g] <= req_i[g];
        irr_q[g]  <= (irr_q[g] & ~take_mask[g]) | (req_i[g] & ~prev_q[g]);
        isr_q[g]  <= init_i ? 1'b0 : ((isr_q[g] & ~clr_mask[g]) | take_mask[g]);
      end
    end
  end

  assign irr_o = irr_q;
  assign isr_o = isr_q;
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl #(
  parameter int unsigned N_IN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            addr_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [N_IN-1:0] wdata_i,
  output logic [N_IN-1:0] rdata_o,
  input  logic [N_IN-1:0] req_i,
  output logic            irq_o,
  input  logic            ack_i,
  output logic [N_IN-1:0] vector_o,
  output logic [N_IN-1:0] cascade_o
);
  localparam int unsigned LVL_W = $clog2(N_IN);
  localparam int unsigned PAD_W = N_IN - 1 - LVL_W;

  logic             ready, smm, rsel_isr, poll, init, eoi_ns, eoi_sp, grant, take;
  logic [LVL_W-1:0] eoi_lvl, grant_lvl;
  logic [N_IN-1:0]  imr, base, irr, isr;

  pic8_cfg #(.N(N_IN), .LVL_W(LVL_W)) u_cfg (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i,
    .ready_o(ready), .imr_o(imr), .base_o(base), .casc_o(cascade_o),
    .smm_o(smm), .rsel_isr_o(rsel_isr), .poll_o(poll), .init_o(init),
    .eoi_ns_o(eoi_ns), .eoi_sp_o(eoi_sp), .eoi_lvl_o(eoi_lvl)
  );

  assign take = ack_i | (rd_i & poll);

  pic8_regs #(.N(N_IN), .LVL_W(LVL_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .imr_i(imr), .smm_i(smm), .ready_i(ready),
    .init_i(init), .take_i(take), .eoi_ns_i(eoi_ns), .eoi_sp_i(eoi_sp),
    .eoi_lvl_i(eoi_lvl), .irr_o(irr), .isr_o(isr), .grant_o(grant),
    .grant_lvl_o(grant_lvl)
  );

  assign irq_o    = grant;
  assign vector_o = {base[N_IN-1:LVL_W], grant ? grant_lvl : {LVL_W{1'b1}}};

  always_comb begin
    if (poll)        rdata_o = {grant, {PAD_W{1'b0}}, grant ? grant_lvl : {LVL_W{1'b0}}};
    else if (addr_i) rdata_o = rsel_isr ? isr : irr;
    else             rdata_o = imr;
  end
endmodule

// File: rtl/pic8_ctrl_chk.sv
module pic8_ctrl_chk #(
  parameter int unsigned N_IN = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            addr_i,
  input logic            wr_i,
  input logic            rd_i,
  input logic [N_IN-1:0] wdata_i,
  input logic [N_IN-1:0] rdata_o,
  input logic            ack_i,
  input logic            irq_o,
  input logic            ready,
  input logic            poll,
  input logic [N_IN-1:0] irr,
  input logic [N_IN-1:0] imr,
  input logic [N_IN-1:0] isr
);
  assert_quiet_until_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |-> !irq_o);

  assert_irq_has_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((irr & ~imr) != '0));

  assert_ack_enters_service_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !wr_i) |=> (isr != '0));

  assert_spec_eoi_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && wdata_i[7:5] == 3'b011 && wdata_i[4:3] == 2'b00 && !ack_i && !rd_i)
    |=> !isr[$past(wdata_i[2:0])]);

  assert_poll_read_takes_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && poll && rdata_o[7] && !wr_i) |=> (isr != '0));
endmodule

bind pic8_ctrl pic8_ctrl_chk #(.N_IN(N_IN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_i(ack_i), .irq_o(irq_o),
  .ready(ready), .poll(poll), .irr(irr), .imr(imr), .isr(isr)
);

// File: tb/pic8_ctrl_test.sv
`timescale 1ns/100ps
module pic8_ctrl_test;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       addr_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0, ack_i = 1'b0;
  logic [7:0] wdata_i = '0, req_i = '0;
  logic [7:0] rdata_o, vector_o, cascade_o;
  logic       irq_o;
  int         n_run = 0, n_fail = 0, cycles = 0;

  always #2.5 clk = ~clk;

  pic8_ctrl uut (
    .clk_i(clk), .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
    .req_i, .irq_o, .ack_i, .vector_o, .cascade_o
  );

  // behavioural reference
  int         m_st;
  bit         m_n3, m_n4, m_smm, m_rsel, m_poll;
  logic [7:0] m_irr, m_isr, m_imr, m_base, m_casc, m_prev;

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic int grant_lvl();
    int pl, el;
    pl = lowest(m_irr & ~m_imr);
    el = lowest(m_smm ? (m_isr & ~m_imr) : m_isr);
    if (m_st == 4 && pl < 8 && pl < el) return pl;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_n3 = 0; m_n4 = 0; m_smm = 0; m_rsel = 0; m_poll = 0;
      m_irr = 0; m_isr = 0; m_imr = 8'hFF; m_base = 0; m_casc = 0; m_prev = 0;
    end else begin
      int g;
      logic [7:0] tk, clr;
      g = grant_lvl();
      tk = 0; clr = 0;
      if (g >= 0 && (ack_i || (rd_i && m_poll))) tk[g] = 1'b1;
      if (rd_i && m_poll) m_poll = 0;
      if (wr_i && !addr_i && !wdata_i[4] && !wdata_i[3]) begin
        if (wdata_i[7:5] == 3'd1 && m_isr != 0) clr[lowest(m_isr)] = 1'b1;
        if (wdata_i[7:5] == 3'd3) clr[wdata_i[2:0]] = 1'b1;
      end
      m_irr = (m_irr & ~tk) | (req_i & ~m_prev);
      m_prev = req_i;
      if (wr_i && !addr_i && wdata_i[4]) begin
        m_isr = 0; m_st = 1; m_n3 = !wdata_i[1]; m_n4 = wdata_i[0];
        m_imr = 0; m_smm = 0; m_rsel = 0; m_poll = 0;
      end else begin
        m_isr = (m_isr & ~clr) | tk;
        if (wr_i && addr_i) begin
          case (m_st)
            1: begin m_base = wdata_i; m_st = m_n3 ? 2 : (m_n4 ? 3 : 4); end
            2: begin m_casc = wdata_i; m_st = m_n4 ? 3 : 4; end
            3: m_st = 4;
            4: m_imr = wdata_i;
            default: ;
          endcase
        end else if (wr_i && !addr_i && wdata_i[3]) begin
          if (wdata_i[6]) m_smm = wdata_i[5];
          if (wdata_i[1]) m_rsel = wdata_i[0];
          if (wdata_i[2]) m_poll = 1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always begin
    @(negedge clk);
    #2;
    if (rst_ni) begin
      int g;
      logic [7:0] ev, er;
      g = grant_lvl();
      ev = {m_base[7:3], (g >= 0) ? 3'(g) : 3'd7};
      if (m_poll) er = {g >= 0, 4'b0, (g >= 0) ? 3'(g) : 3'd0};
      else if (addr_i) er = m_rsel ? m_isr : m_irr;
      else er = m_imr;
      chk("R6 irq", {7'b0, irq_o}, {7'b0, g >= 0});
      chk("R3 vector", vector_o, ev);
      chk("R11 rdata", rdata_o, er);
      chk("R3 cascade", cascade_o, m_casc);
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      wr_i = 0; rd_i = 0; ack_i = 0;
    end
  endtask

  task automatic put(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_i = 1;
    @(negedge clk);
    wr_i = 0;
  endtask

  task automatic look(input string req, input logic a, input logic [7:0] exp);
    @(negedge clk);
    addr_i = a;
    #1 chk(req, rdata_o, exp);
  endtask

  task automatic pull(input string req, input logic a, input logic [7:0] exp);
    @(negedge clk);
    addr_i = a; rd_i = 1;
    #1 chk(req, rdata_o, exp);
    @(negedge clk);
    rd_i = 0;
  endtask

  task automatic take(input string req, input logic [7:0] exp);
    @(negedge clk);
    ack_i = 1;
    #1 chk(req, vector_o, exp);
    @(negedge clk);
    ack_i = 0;
  endtask

  task automatic irq_is(input string req, input logic exp);
    @(negedge clk);
    #1 chk(req, {7'b0, irq_o}, {7'b0, exp});
  endtask

  task automatic drive_req(input logic [7:0] v);
    @(negedge clk);
    req_i = v;
    idle(1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    @(negedge clk) rst_ni = 1;
    irq_is("R1 irq low after reset", 1'b0);
    look("R1 mask after reset", 1'b0, 8'hFF);
    look("R1 irr after reset", 1'b1, 8'h00);
    put(1'b1, 8'h00);
    look("R1 data write ignored", 1'b0, 8'hFF);

    put(1'b0, 8'h11); put(1'b1, 8'h20); put(1'b1, 8'h04); put(1'b1, 8'h01);
    look("R2 mask cleared by init", 1'b0, 8'h00);
    chk("R3 cascade word", cascade_o, 8'h04);
    put(1'b1, 8'hF0);
    look("R5 mask loaded", 1'b0, 8'hF0);

    drive_req(8'h20);
    irq_is("R5 masked level silent", 1'b0);
    look("R4 masked edge latched", 1'b1, 8'h20);
    drive_req(8'h28);
    irq_is("R6 level 3 raises irq", 1'b1);
    take("R7 vector level 3", 8'h23);
    put(1'b0, 8'h0B);
    look("R11 isr readback", 1'b1, 8'h08);

    drive_req(8'h2A);
    irq_is("R6 level 1 pre-empts 3", 1'b1);
    take("R7 vector level 1", 8'h21);
    drive_req(8'h2E);
    irq_is("R6 level 2 blocked by 1", 1'b0);
    put(1'b0, 8'h20);
    look("R8 nonspecific eoi", 1'b1, 8'h08);
    irq_is("R6 level 2 now above 3", 1'b1);
    put(1'b0, 8'h40);
    put(1'b0, 8'hA0);
    look("R10 other codes no effect", 1'b1, 8'h08);
    put(1'b0, 8'h63);
    look("R9 specific eoi", 1'b1, 8'h00);

    take("R7 vector level 2", 8'h22);
    put(1'b0, 8'h0A);
    look("R4 held request not relatched", 1'b1, 8'h20);
    take("R7 spurious vector", 8'h27);
    put(1'b0, 8'h0B);
    look("R7 spurious leaves isr", 1'b1, 8'h04);
    put(1'b0, 8'h09);
    look("R11 selection kept", 1'b1, 8'h04);

    put(1'b1, 8'h04);
    irq_is("R6 level 5 blocked by 2", 1'b0);
    put(1'b0, 8'h68);
    irq_is("R12 special mask unblocks", 1'b1);
    put(1'b0, 8'h48);
    irq_is("R12 special mask off", 1'b0);

    put(1'b0, 8'h0C);
    pull("R13 poll nothing pending", 1'b0, 8'h00);
    look("R13 poll single shot", 1'b0, 8'h04);
    put(1'b0, 8'h68);
    put(1'b0, 8'h0C);
    pull("R13 poll pending level 5", 1'b1, 8'h85);
    look("R13 poll acknowledged", 1'b1, 8'h24);

    put(1'b0, 8'h13); put(1'b1, 8'h08); put(1'b1, 8'h01);
    chk("R2 single mode skips cascade", cascade_o, 8'h04);
    look("R2 mask cleared", 1'b0, 8'h00);
    put(1'b0, 8'h0B);
    look("R2 isr cleared", 1'b1, 8'h00);
    drive_req(8'h00);
    drive_req(8'h01);
    irq_is("R6 level 0 raises irq", 1'b1);
    take("R3 base 08 vector", 8'h08);

    put(1'b0, 8'h10); put(1'b1, 8'h30); put(1'b1, 8'h80);
    chk("R2 cascade without mode word", cascade_o, 8'h80);
    put(1'b1, 8'hFE);
    look("R2 ready after two words", 1'b0, 8'hFE);

    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule